// File: doc/BRIEF.md
# Edge-Qualified Interrupt Message Builder

This block sits between a set of interrupt input pins and an interrupt delivery fabric. Each pin has a routing entry, supplied on flat input buses: a vector, a 3-bit delivery mode, a destination mode bit, a destination, a polarity bit, a trigger-mode bit and a mask bit. The block keeps one remembered state bit per pin. A pin produces a delivery request only when it is seen high while its remembered state is low. Every pin's remembered state follows the pin every cycle, whether or not the pin is masked.

Requests from unmasked pins are latched in a pending bitmap. They are issued through a registered output stage with a valid/ready handshake, at most one message per cycle, with the lowest pin number first. In the external-interrupt delivery mode, the message vector is taken from a separate vector input at the moment the message is loaded into the output stage. In every other mode, the entry's own vector is used. Destination resolution and register programming are handled elsewhere. An optional input synchronizer, set by a parameter, can be placed in front of the edge detection.

Top module: `irq_msg_builder`

## Requirements
- R1: A delivery request is created for a pin only when the pin is sampled high while its remembered state is low. A pin that stays high creates exactly one message.
- R2: On every clock, each pin's remembered state takes the pin's sampled level. This holds for masked pins as well, and whether or not a request was created.
- R3: A pin going from high to low never produces a message.
- R4: A rising pin whose mask bit is 1 when the rise is detected is dropped. Clearing the mask while the pin stays high produces nothing. The pin has to go low and then high again before it can fire.
- R5: When the entry's delivery mode is 3'b111 (external interrupt), the message vector equals `ext_vector_i` as sampled on the clock edge that loads the message into the output stage. Later changes to `ext_vector_i` do not alter a message that is already presented.
- R6: In any other delivery mode, the message vector is the entry's vector. In all modes, the message carries the entry's delivery mode, destination mode and destination. The level field is the entry's polarity bit, the trigger field is the entry's trigger bit, and `msg_pin_o` is the pin number.
- R7: Reset clears every remembered state, every pending request and `msg_valid_o`. A pin that is held high through reset therefore fires once after reset is released.
- R8: Requests pending on several pins are issued in ascending pin order, one per accepted message.
- R9: While `msg_valid_o` is high and `msg_ready_i` is low, the presented message and `msg_valid_o` are held unchanged. Requests that arrive in the meantime stay pending and are not lost.
- R10: With SYNC_STAGES = 0 and an empty output stage, a rise sampled on clock edge k appears on `msg_valid_o` after edge k+1. While `msg_ready_i` stays high, pending requests are issued on consecutive cycles.
- R11: A second rise on a pin whose earlier request is still pending merges with it, so only one message is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Interrupt input levels |
| ent_mask_i | input | NUM_PINS | Per-pin mask bit |
| ent_vector_i | input | NUM_PINS*VEC_W | Per-pin vector, pin i at bits [i*VEC_W +: VEC_W] |
| ent_mode_i | input | NUM_PINS*3 | Per-pin delivery mode, 3'b111 = external interrupt |
| ent_dest_mode_i | input | NUM_PINS | Per-pin destination mode bit |
| ent_dest_i | input | NUM_PINS*DEST_W | Per-pin destination |
| ent_polarity_i | input | NUM_PINS | Per-pin polarity, copied to the level field |
| ent_trigger_i | input | NUM_PINS | Per-pin trigger mode, copied to the trigger field |
| ext_vector_i | input | VEC_W | Vector from the legacy controller |
| msg_valid_o | output | 1 | Message presented |
| msg_ready_i | input | 1 | Consumer accepts the message |
| msg_pin_o | output | $clog2(NUM_PINS) | Source pin number |
| msg_vector_o | output | VEC_W | Message vector |
| msg_mode_o | output | 3 | Delivery mode |
| msg_dest_mode_o | output | 1 | Destination mode |
| msg_dest_o | output | DEST_W | Destination |
| msg_level_o | output | 1 | Level field |
| msg_trigger_o | output | 1 | Trigger field |

## Verification
The bench holds a pin high for many cycles and then lowers it. A design that compares against the previous raw sample incorrectly, or that fires on the falling edge, would produce extra messages here. It unmasks a pin that is still high and expects silence, which catches a design that skips the state update for masked pins. It changes the external vector while an external-interrupt message is stalled, which exposes a vector that is muxed live instead of captured. It also fires three pins in one cycle and re-fires a pin that is still pending, under back-pressure. A wrong priority order, a lost request or a duplicate message would each show up as a mismatch in the logged message sequence.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      DM_FIXED   = 3'b000,
      DM_LOWEST  = 3'b001,
      DM_SMI     = 3'b010,
      DM_RSVD3   = 3'b011,
      DM_NMI     = 3'b100,
      DM_INIT    = 3'b101,
      DM_RSVD6   = 3'b110,
      DM_EXTINT  = 3'b111
   } dmode_e;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
   parameter int NUM_PINS    = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins_i,
   input  logic [NUM_PINS-1:0] mask_i,
   output logic [NUM_PINS-1:0] pins_s_o,
   output logic [NUM_PINS-1:0] state_o,
   output logic [NUM_PINS-1:0] events_o
);

   logic [NUM_PINS-1:0] pins_s;
   logic [NUM_PINS-1:0] state_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pins_s = pins_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0][NUM_PINS-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= pins_i;
               for (int k = 1; k < SYNC_STAGES; k++) begin
                  chain_q[k] <= chain_q[k-1];
               end
            end
         end
         assign pins_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   // remembered level, updated for every pin regardless of mask
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= '0;
      else        state_q <= pins_s;
   end

   assign events_o = pins_s & ~state_q & ~mask_i;
   assign state_o  = state_q;
   assign pins_s_o = pins_s;

endmodule

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
   parameter int NUM_PINS = 8,
   parameter int PIN_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] events_i,
   input  logic                take_i,
   output logic [NUM_PINS-1:0] pend_o,
   output logic                any_o,
   output logic [PIN_W-1:0]    idx_o
);

   logic [NUM_PINS-1:0] pend_q;
   logic [NUM_PINS-1:0] grant_oh;

   // lowest-numbered pending pin wins
   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_grant
         if (i == 0) begin : g_first
            assign grant_oh[0] = pend_q[0];
         end else begin : g_rest
            assign grant_oh[i] = pend_q[i] & ~(|pend_q[i-1:0]);
         end
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (grant_oh[i]) idx_o = idx_o | PIN_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~(take_i ? grant_oh : '0)) | events_i;
   end

   assign pend_o = pend_q;
   assign any_o  = |pend_q;

   p_take_needs_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> any_o);

   p_taken_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> (pend_q & $past(grant_oh & ~events_i)) == '0);

endmodule

// File: rtl/irq_msg_form.sv
module irq_msg_form
   import irq_msg_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int PIN_W    = 3,
   parameter int VEC_W    = 8,
   parameter int DEST_W   = 8
) (
   input  logic [PIN_W-1:0]           idx_i,
   input  logic [NUM_PINS*VEC_W-1:0]  ent_vector_i,
   input  logic [NUM_PINS*MODE_W-1:0] ent_mode_i,
   input  logic [NUM_PINS-1:0]        ent_dest_mode_i,
   input  logic [NUM_PINS*DEST_W-1:0] ent_dest_i,
   input  logic [NUM_PINS-1:0]        ent_polarity_i,
   input  logic [NUM_PINS-1:0]        ent_trigger_i,
   input  logic [VEC_W-1:0]           ext_vector_i,
   output logic [VEC_W-1:0]           vector_o,
   output logic [MODE_W-1:0]          mode_o,
   output logic                       dest_mode_o,
   output logic [DEST_W-1:0]          dest_o,
   output logic                       level_o,
   output logic                       trigger_o
);

   int sel;

   always_comb begin
      sel         = int'(idx_i);
      mode_o      = ent_mode_i[sel*MODE_W +: MODE_W];
      dest_o      = ent_dest_i[sel*DEST_W +: DEST_W];
      dest_mode_o = ent_dest_mode_i[sel];
      level_o     = ent_polarity_i[sel];
      trigger_o   = ent_trigger_i[sel];
      if (mode_o == DM_EXTINT) vector_o = ext_vector_i;
      else                     vector_o = ent_vector_i[sel*VEC_W +: VEC_W];
   end

endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
   parameter int MSG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [MSG_W-1:0] msg_d_i,
   input  logic             ready_i,
   output logic             valid_o,
   output logic             free_o,
   output logic [MSG_W-1:0] msg_q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         msg_q_o <= '0;
      end else if (load_i) begin
         valid_o <= 1'b1;
         msg_q_o <= msg_d_i;
      end else if (ready_i) begin
         valid_o <= 1'b0;
      end
   end

   assign free_o = !valid_o || ready_i;

   p_hold_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(msg_q_o)));

endmodule

// File: rtl/irq_msg_builder.sv
module irq_msg_builder
   import irq_msg_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int VEC_W       = 8,
   parameter int DEST_W      = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_PINS-1:0]           pins_i,
   input  logic [NUM_PINS-1:0]           ent_mask_i,
   input  logic [NUM_PINS*VEC_W-1:0]     ent_vector_i,
   input  logic [NUM_PINS*3-1:0]         ent_mode_i,
   input  logic [NUM_PINS-1:0]           ent_dest_mode_i,
   input  logic [NUM_PINS*DEST_W-1:0]    ent_dest_i,
   input  logic [NUM_PINS-1:0]           ent_polarity_i,
   input  logic [NUM_PINS-1:0]           ent_trigger_i,
   input  logic [VEC_W-1:0]              ext_vector_i,
   output logic                          msg_valid_o,
   input  logic                          msg_ready_i,
   output logic [$clog2(NUM_PINS)-1:0]   msg_pin_o,
   output logic [VEC_W-1:0]              msg_vector_o,
   output logic [2:0]                    msg_mode_o,
   output logic                          msg_dest_mode_o,
   output logic [DEST_W-1:0]             msg_dest_o,
   output logic                          msg_level_o,
   output logic                          msg_trigger_o
);

   localparam int PIN_W = $clog2(NUM_PINS);
   localparam int MSG_W = PIN_W + VEC_W + MODE_W + 1 + DEST_W + 1 + 1;

   generate
      if (NUM_PINS < 2 || NUM_PINS > 64) begin : g_bad_pins
         $error("NUM_PINS must lie in 2..64");
      end
      if (VEC_W < 1 || DEST_W < 1) begin : g_bad_width
         $error("VEC_W and DEST_W must be positive");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   logic [NUM_PINS-1:0] pins_s, state, events, pend;
   logic                any, take, free;
   logic [PIN_W-1:0]    idx;
   logic [VEC_W-1:0]    f_vector;
   logic [MODE_W-1:0]   f_mode;
   logic                f_dest_mode, f_level, f_trigger;
   logic [DEST_W-1:0]   f_dest;
   logic [MSG_W-1:0]    msg_d, msg_q;

   irq_edge_detect #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins_i   (pins_i),
      .mask_i   (ent_mask_i),
      .pins_s_o (pins_s),
      .state_o  (state),
      .events_o (events)
   );

   irq_pend_arb #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .events_i (events),
      .take_i   (take),
      .pend_o   (pend),
      .any_o    (any),
      .idx_o    (idx)
   );

   irq_msg_form #(
      .NUM_PINS(NUM_PINS), .PIN_W(PIN_W), .VEC_W(VEC_W), .DEST_W(DEST_W)
   ) u_form (
      .idx_i           (idx),
      .ent_vector_i    (ent_vector_i),
      .ent_mode_i      (ent_mode_i),
      .ent_dest_mode_i (ent_dest_mode_i),
      .ent_dest_i      (ent_dest_i),
      .ent_polarity_i  (ent_polarity_i),
      .ent_trigger_i   (ent_trigger_i),
      .ext_vector_i    (ext_vector_i),
      .vector_o        (f_vector),
      .mode_o          (f_mode),
      .dest_mode_o     (f_dest_mode),
      .dest_o          (f_dest),
      .level_o         (f_level),
      .trigger_o       (f_trigger)
   );

   assign take  = any && free;
   assign msg_d = {idx, f_vector, f_mode, f_dest_mode, f_dest, f_level, f_trigger};

   irq_out_reg #(.MSG_W(MSG_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (take),
      .msg_d_i (msg_d),
      .ready_i (msg_ready_i),
      .valid_o (msg_valid_o),
      .free_o  (free),
      .msg_q_o (msg_q)
   );

   assign {msg_pin_o, msg_vector_o, msg_mode_o, msg_dest_mode_o,
           msg_dest_o, msg_level_o, msg_trigger_o} = msg_q;

   // newly pending bits must come from a low-to-high change on an unmasked pin
   p_rise_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ~$past(pend) & ~($past(pins_s) & ~$past(state))) == '0);

   p_masked_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ~$past(pend) & $past(ent_mask_i)) == '0);

   p_ext_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && f_mode == DM_EXTINT) |=> (msg_vector_o == $past(ext_vector_i)));

   p_valid_has_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_valid_o) |-> $past(any));

endmodule

// File: tb/tb_irq_msg_builder.sv
module tb_irq_msg_builder;

   localparam int N  = 8;
   localparam int VW = 8;
   localparam int DW = 8;
   localparam int PW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pins = '0;
   logic [N-1:0]  mask = '0;
   logic [N*VW-1:0] e_vec;
   logic [N*3-1:0]  e_mode;
   logic [N-1:0]    e_dm, e_pol, e_trg;
   logic [N*DW-1:0] e_dest;
   logic [VW-1:0]   ext_vec = 8'h00;
   logic            ready = 1'b1;

   logic          msg_valid;
   logic [PW-1:0] msg_pin;
   logic [VW-1:0] msg_vec;
   logic [2:0]    msg_mode;
   logic          msg_dm, msg_lvl, msg_trg;
   logic [DW-1:0] msg_dest;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   int   log_n = 0;
   int   log_pin [32];
   int   log_vec [32];
   int   log_mode[32];
   int   log_dm  [32];
   int   log_dest[32];
   int   log_lvl [32];
   int   log_trg [32];
   int   log_cyc [32];

   irq_msg_builder #(.NUM_PINS(N), .VEC_W(VW), .DEST_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .ent_mask_i(mask),
      .ent_vector_i(e_vec), .ent_mode_i(e_mode), .ent_dest_mode_i(e_dm),
      .ent_dest_i(e_dest), .ent_polarity_i(e_pol), .ent_trigger_i(e_trg),
      .ext_vector_i(ext_vec), .msg_valid_o(msg_valid), .msg_ready_i(ready),
      .msg_pin_o(msg_pin), .msg_vector_o(msg_vec), .msg_mode_o(msg_mode),
      .msg_dest_mode_o(msg_dm), .msg_dest_o(msg_dest),
      .msg_level_o(msg_lvl), .msg_trigger_o(msg_trg)
   );

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // log every accepted message, sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n && msg_valid && ready && log_n < 32) begin
         log_pin[log_n]  <= int'(msg_pin);
         log_vec[log_n]  <= int'(msg_vec);
         log_mode[log_n] <= int'(msg_mode);
         log_dm[log_n]   <= int'(msg_dm);
         log_dest[log_n] <= int'(msg_dest);
         log_lvl[log_n]  <= int'(msg_lvl);
         log_trg[log_n]  <= int'(msg_trg);
         log_cyc[log_n]  <= cyc;
         log_n           <= log_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic set_entry(input int p, input int vec, input int mode,
                            input int dm, input int dest, input int pol, input int trg);
      e_vec[p*VW +: VW]   = VW'(vec);
      e_mode[p*3 +: 3]    = 3'(mode);
      e_dm[p]             = 1'(dm);
      e_dest[p*DW +: DW]  = DW'(dest);
      e_pol[p]            = 1'(pol);
      e_trg[p]            = 1'(trg);
   endtask

   task automatic chk_fields(input int k, input int p, input int vec, input string req);
      chk(log_pin[k]  == p, req, log_pin[k], p);
      chk(log_vec[k]  == vec, req, log_vec[k], vec);
      chk(log_mode[k] == int'(e_mode[p*3 +: 3]), req, log_mode[k], int'(e_mode[p*3 +: 3]));
      chk(log_dm[k]   == int'(e_dm[p]), req, log_dm[k], int'(e_dm[p]));
      chk(log_dest[k] == int'(e_dest[p*DW +: DW]), req, log_dest[k], int'(e_dest[p*DW +: DW]));
      chk(log_lvl[k]  == int'(e_pol[p]), req, log_lvl[k], int'(e_pol[p]));
      chk(log_trg[k]  == int'(e_trg[p]), req, log_trg[k], int'(e_trg[p]));
   endtask

   task automatic t_reset;
      // pin 3 held high through reset
      step(2);
      chk(msg_valid == 1'b0, "R7 valid in reset", int'(msg_valid), 0);
      rst_n = 1'b1;
      step(5);
      chk(log_n == 1, "R7 held pin fires once", log_n, 1);
      if (log_n > 0) chk(log_pin[0] == 3, "R7 pin", log_pin[0], 3);
      pins[3] = 1'b0;
      step(3);
      log_n = 0;
   endtask

   task automatic t_basic;
      int c0;
      set_entry(2, 8'h41, 0, 1, 8'h05, 1, 0);
      pins[2] = 1'b1;
      c0 = cyc;
      step(4);
      chk(log_n == 1, "R1 one message", log_n, 1);
      chk_fields(0, 2, 8'h41, "R6 fields");
      chk(log_cyc[0] == c0 + 2, "R10 latency", log_cyc[0], c0 + 2);
      step(6);
      chk(log_n == 1, "R2 held high no repeat", log_n, 1);
      pins[2] = 1'b0;
      step(5);
      chk(log_n == 1, "R3 fall silent", log_n, 1);
      log_n = 0;
   endtask

   task automatic t_mask;
      mask[4] = 1'b1;
      pins[4] = 1'b1;
      step(5);
      chk(log_n == 0, "R4 masked dropped", log_n, 0);
      mask[4] = 1'b0;
      step(5);
      chk(log_n == 0, "R2 unmask while high silent", log_n, 0);
      pins[4] = 1'b0;
      step(1);
      pins[4] = 1'b1;
      step(4);
      chk(log_n == 1, "R4 refire after toggle", log_n, 1);
      if (log_n > 0) chk(log_pin[0] == 4, "R4 pin", log_pin[0], 4);
      pins[4] = 1'b0;
      step(2);
      log_n = 0;
   endtask

   task automatic t_ext;
      set_entry(1, 8'h11, 7, 0, 8'hA0, 0, 1);
      set_entry(6, 8'h66, 4, 1, 8'h3C, 1, 1);
      ext_vec = 8'h9C;
      pins[1] = 1'b1;
      step(4);
      pins[6] = 1'b1;
      step(4);
      chk(log_n == 2, "R5 count", log_n, 2);
      chk_fields(0, 1, 8'h9C, "R5 ext vector");
      chk_fields(1, 6, 8'h66, "R6 non-ext uses entry");
      pins[1] = 1'b0;
      pins[6] = 1'b0;
      step(2);
      log_n = 0;
      // capture at load: change after load while stalled
      ready = 1'b0;
      pins[1] = 1'b1;
      step(3);
      ext_vec = 8'h55;
      step(2);
      ready = 1'b1;
      step(2);
      chk(log_n == 1, "R5 stalled count", log_n, 1);
      if (log_n > 0) chk(log_vec[0] == 8'h9C, "R5 captured at load", log_vec[0], 8'h9C);
      pins[1] = 1'b0;
      step(2);
      log_n = 0;
   endtask

   task automatic t_multi;
      pins[6] = 1'b1;
      pins[0] = 1'b1;
      pins[3] = 1'b1;
      step(6);
      chk(log_n == 3, "R8 count", log_n, 3);
      chk(log_pin[0] == 0, "R8 first", log_pin[0], 0);
      chk(log_pin[1] == 3, "R8 second", log_pin[1], 3);
      chk(log_pin[2] == 6, "R8 third", log_pin[2], 6);
      chk(log_cyc[1] == log_cyc[0] + 1, "R10 back to back", log_cyc[1], log_cyc[0] + 1);
      chk(log_cyc[2] == log_cyc[1] + 1, "R10 back to back", log_cyc[2], log_cyc[1] + 1);
      pins = '0;
      step(2);
      log_n = 0;
   endtask

   task automatic t_stall;
      ready = 1'b0;
      pins[7] = 1'b1;
      pins[5] = 1'b1;
      step(3);
      chk(msg_valid == 1'b1, "R9 valid presented", int'(msg_valid), 1);
      chk(int'(msg_pin) == 5, "R9 presented pin", int'(msg_pin), 5);
      step(4);
      chk(msg_valid == 1'b1, "R9 valid held", int'(msg_valid), 1);
      chk(int'(msg_pin) == 5, "R9 pin held", int'(msg_pin), 5);
      ready = 1'b1;
      step(4);
      chk(log_n == 2, "R9 none lost", log_n, 2);
      if (log_n == 2) begin
         chk(log_pin[0] == 5, "R9 order", log_pin[0], 5);
         chk(log_pin[1] == 7, "R9 order", log_pin[1], 7);
      end
      pins = '0;
      step(2);
      log_n = 0;
   endtask

   task automatic t_merge;
      ready = 1'b0;
      pins[0] = 1'b1;
      step(3);
      pins[2] = 1'b1;
      step(1);
      pins[2] = 1'b0;
      step(1);
      pins[2] = 1'b1;
      step(3);
      ready = 1'b1;
      step(5);
      chk(log_n == 2, "R11 merged count", log_n, 2);
      if (log_n == 2) begin
         chk(log_pin[0] == 0, "R11 first", log_pin[0], 0);
         chk(log_pin[1] == 2, "R11 second", log_pin[1], 2);
      end
      pins = '0;
      step(2);
      log_n = 0;
   endtask

   initial begin
      for (int p = 0; p < N; p++) set_entry(p, 8'h20 + p, 0, 0, p * 3, 0, 0);
      pins[3] = 1'b1;
      t_reset();
      t_basic();
      t_mask();
      t_ext();
      t_multi();
      t_stall();
      t_merge();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule